// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block holds a small bank of hardware breakpoint and watchpoint comparators for a processor that runs at either 32-bit or 64-bit register width. Every cycle it looks at one access descriptor: the operation kind, the address, the data, the current privilege level, a flag saying the hart runs at 32-bit width, and the current debug cause. It reports, combinationally, whether a trigger fired, which one, and the action code stored for that trigger. Carrying out the action is left to the surrounding logic.

Each trigger has a configuration word and a full-width compare value. Both are loaded through one write port, addressed by trigger index plus a kind bit. A trigger is filtered by operation kind and privilege. It then compares either the address or the data against its compare value in one of six modes. Triggers can be chained so that several conditions must all hold before the last one in the chain fires. All firing is suppressed while the hart sits in debug state.

The access descriptor is a plain per-cycle input: there is no handshake, and the outputs follow the inputs within the same cycle. The write port is a single-cycle strobe and can never be back-pressured.

Top module: `trig_match_unit`

## Requirements
- R1: After reset, every configuration word and compare value is zero, so no trigger fires for any access.
- R2: With `wr_en` high, a clock edge stores `wr_data` into trigger `wr_idx`. The configuration word (low 14 bits) is written when `wr_kind`=0, and the compare value when `wr_kind`=1. The configuration fields are: mode [2:0], action [5:3], chain [6], use-data [7], execute enable [8], store enable [9], load enable [10], machine enable [11], supervisor enable [12], user enable [13].
- R3: While `dbg_cause` is nonzero, `hit` stays low whatever the configuration.
- R4: `acc_op` 0 = execute, 1 = store, 2 = load, 3 = no access. A trigger takes part only if its enable bit for that kind is set; with code 3 nothing fires.
- R5: `acc_priv` 0 = user, 1 = supervisor, 3 = machine, 2 = invalid. A trigger takes part only if its enable bit for that level is set; with code 2 nothing fires.
- R6: The compared value is `acc_data` when use-data is set and `acc_addr` otherwise. When `acc_narrow` is high, the value is cut to its low 32 bits before comparing; the compare value is not cut.
- R7: Mode 0 fires on value == compare. Mode 2 fires on value >= compare (unsigned). Mode 3 fires on value < compare (unsigned).
- R8: Mode 1 counts n, the run of one bits at the bottom of the compare value. It fires when value and compare agree in every bit from n upward; if all bits are ones it always fires.
- R9: Let h be 16 in narrow mode and XLEN/2 otherwise, and m = compare >> h. Mode 4 fires when (value & m) == (compare & m). Mode 5 fires when ((value >> h) & m) == (compare & m). Modes 6 and 7 never fire.
- R10: A chain is a run of triggers with the chain bit set, ended by the next trigger with the bit clear. The chain fires, reporting the ending trigger, only if every member passes its filters and compare. If any member fails, the rest of that chain is ignored and scanning restarts after its end. A chain still open at the last trigger never fires.
- R11: Among firing triggers the lowest index wins. `hit_action` carries that trigger's action field. When nothing fires, `hit_idx` and `hit_action` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the trigger store |
| wr_kind | input | 1 | 0 = configuration word, 1 = compare value |
| wr_idx | input | IDX_W | Trigger index to write |
| wr_data | input | XLEN | Write data |
| acc_op | input | 2 | Operation kind of the access |
| acc_priv | input | 2 | Privilege level of the access |
| acc_narrow | input | 1 | Hart runs at 32-bit width |
| acc_addr | input | XLEN | Access address |
| acc_data | input | XLEN | Access data |
| dbg_cause | input | 3 | Debug cause, nonzero while halted |
| hit | output | 1 | A trigger fired |
| hit_idx | output | IDX_W | Index of the firing trigger |
| hit_action | output | 3 | Action code of the firing trigger |

## Verification
The bench builds the block with its defaults: four triggers and a 64-bit width. With only four triggers, every one of the 16 chain-bit patterns can be crossed with all 16 per-trigger pass/fail patterns. The full 64-combination grid of operation and privilege enables can be crossed with every operation and privilege code. The 64-bit width lets one sweep cover both the narrow path (truncation, h = 16) and the wide path (h = 32) of every compare mode, with sign-extended style values that tell them apart.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam int CFG_W = 14;

  typedef enum logic [2:0] {
    MODE_EQ    = 3'd0,
    MODE_RANGE = 3'd1,
    MODE_GE    = 3'd2,
    MODE_LT    = 3'd3,
    MODE_MLO   = 3'd4,
    MODE_MHI   = 3'd5
  } cmp_mode_e;

  typedef struct packed {
    logic      en_u;
    logic      en_s;
    logic      en_m;
    logic      en_load;
    logic      en_store;
    logic      en_exec;
    logic      use_data;
    logic      chain;
    logic [2:0] action;
    cmp_mode_e mode;
  } trig_cfg_t;

  localparam logic [1:0] OP_EXEC  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;
  localparam logic [1:0] OP_LOAD  = 2'd2;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

endpackage

// File: rtl/trig_regs.sv
module trig_regs
  import trig_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 64,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_kind,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  output trig_cfg_t        cfg_q [NUM_TRIG],
  output logic [XLEN-1:0]  cmp_q [NUM_TRIG]
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TRIG; i++) begin
        cfg_q[i] <= '0;
        cmp_q[i] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < NUM_TRIG; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          if (wr_kind) cmp_q[i] <= wr_data;
          else         cfg_q[i] <= trig_cfg_t'(wr_data[CFG_W-1:0]);
        end
      end
    end
  end

endmodule

// File: rtl/trig_compare.sv
module trig_compare
  import trig_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  cmp_mode_e       mode,
  input  logic            use_data,
  input  logic            en_exec,
  input  logic            en_store,
  input  logic            en_load,
  input  logic            en_m,
  input  logic            en_s,
  input  logic            en_u,
  input  logic [XLEN-1:0] cmp,
  input  logic [XLEN-1:0] addr,
  input  logic [XLEN-1:0] data,
  input  logic            narrow,
  input  logic [1:0]      op,
  input  logic [1:0]      priv,
  output logic            cand
);

  localparam int HALF_W = XLEN / 2;
  localparam logic [XLEN-1:0] LOW32 = XLEN'({32{1'b1}});

  logic            op_ok, priv_ok, val_ok;
  logic [XLEN-1:0] value, keep, half_mask, value_hi;

  // operation-kind filter
  always_comb begin
    case (op)
      OP_EXEC:  op_ok = en_exec;
      OP_STORE: op_ok = en_store;
      OP_LOAD:  op_ok = en_load;
      default:  op_ok = 1'b0;
    endcase
  end

  // privilege filter
  always_comb begin
    case (priv)
      PRIV_U:  priv_ok = en_u;
      PRIV_S:  priv_ok = en_s;
      PRIV_M:  priv_ok = en_m;
      default: priv_ok = 1'b0;
    endcase
  end

  // operand choice and width truncation
  always_comb begin
    value = use_data ? data : addr;
    if (narrow) value = value & LOW32;
  end

  // range mode: bits inside the trailing-ones run are ignored
  always_comb begin
    logic run;
    run = 1'b1;
    for (int k = 0; k < XLEN; k++) begin
      run     = run & cmp[k];
      keep[k] = ~run;
    end
  end

  // split-half operands
  always_comb begin
    if (narrow) begin
      half_mask = cmp >> 16;
      value_hi  = value >> 16;
    end else begin
      half_mask = cmp >> HALF_W;
      value_hi  = value >> HALF_W;
    end
  end

  always_comb begin
    case (mode)
      MODE_EQ:    val_ok = (value == cmp);
      MODE_RANGE: val_ok = (((value ^ cmp) & keep) == '0);
      MODE_GE:    val_ok = (value >= cmp);
      MODE_LT:    val_ok = (value < cmp);
      MODE_MLO:   val_ok = ((value & half_mask) == (cmp & half_mask));
      MODE_MHI:   val_ok = ((value_hi & half_mask) == (cmp & half_mask));
      default:    val_ok = 1'b0;
    endcase
  end

  assign cand = op_ok & priv_ok & val_ok;

endmodule

// File: rtl/trig_resolve.sv
module trig_resolve #(
  parameter int NUM_TRIG = 4,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic [NUM_TRIG-1:0] cand,
  input  logic [NUM_TRIG-1:0] chain,
  input  logic [2:0]          action [NUM_TRIG],
  output logic                res_hit,
  output logic [IDX_W-1:0]    res_idx,
  output logic [2:0]          res_action
);

  // Linear scan: lowest index wins; a failed member poisons its chain.
  always_comb begin
    logic open_ok;
    logic done;
    open_ok    = 1'b1;
    done       = 1'b0;
    res_hit    = 1'b0;
    res_idx    = '0;
    res_action = '0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (!done) begin
        if (!open_ok) begin
          open_ok = ~chain[i];
        end else if (cand[i]) begin
          if (!chain[i]) begin
            res_hit    = 1'b1;
            res_idx    = IDX_W'(i);
            res_action = action[i];
            done       = 1'b1;
          end
        end else begin
          open_ok = ~chain[i];
        end
      end
    end
  end

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import trig_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 64,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_kind,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [1:0]       acc_op,
  input  logic [1:0]       acc_priv,
  input  logic             acc_narrow,
  input  logic [XLEN-1:0]  acc_addr,
  input  logic [XLEN-1:0]  acc_data,
  input  logic [2:0]       dbg_cause,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [2:0]       hit_action
);

  trig_cfg_t           cfg_q [NUM_TRIG];
  logic [XLEN-1:0]     cmp_q [NUM_TRIG];
  logic [NUM_TRIG-1:0] cand;
  logic [NUM_TRIG-1:0] chain;
  logic [2:0]          action [NUM_TRIG];
  logic                res_hit;
  logic [IDX_W-1:0]    res_idx;
  logic [2:0]          res_action;
  logic                halted;

  trig_regs #(.NUM_TRIG(NUM_TRIG), .XLEN(XLEN)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_kind(wr_kind),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .cfg_q  (cfg_q),
    .cmp_q  (cmp_q)
  );

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
    trig_compare #(.XLEN(XLEN)) u_cmp (
      .mode    (cfg_q[g].mode),
      .use_data(cfg_q[g].use_data),
      .en_exec (cfg_q[g].en_exec),
      .en_store(cfg_q[g].en_store),
      .en_load (cfg_q[g].en_load),
      .en_m    (cfg_q[g].en_m),
      .en_s    (cfg_q[g].en_s),
      .en_u    (cfg_q[g].en_u),
      .cmp     (cmp_q[g]),
      .addr    (acc_addr),
      .data    (acc_data),
      .narrow  (acc_narrow),
      .op      (acc_op),
      .priv    (acc_priv),
      .cand    (cand[g])
    );
    assign chain[g]  = cfg_q[g].chain;
    assign action[g] = cfg_q[g].action;
  end

  trig_resolve #(.NUM_TRIG(NUM_TRIG)) u_res (
    .cand      (cand),
    .chain     (chain),
    .action    (action),
    .res_hit   (res_hit),
    .res_idx   (res_idx),
    .res_action(res_action)
  );

  assign halted     = (dbg_cause != 3'd0);
  assign hit        = res_hit & ~halted;
  assign hit_idx    = hit ? res_idx : '0;
  assign hit_action = hit ? res_action : '0;

endmodule

// File: rtl/trig_match_chk.sv
module trig_match_chk
  import trig_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 64,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_kind,
  input logic [IDX_W-1:0] wr_idx,
  input logic [XLEN-1:0]  wr_data,
  input logic [1:0]       acc_op,
  input logic [1:0]       acc_priv,
  input logic [2:0]       dbg_cause,
  input logic             hit,
  input logic [IDX_W-1:0] hit_idx,
  input logic [2:0]       hit_action,
  input trig_cfg_t        cfg_q [NUM_TRIG],
  input logic [XLEN-1:0]  cmp_q [NUM_TRIG]
);

  // R3
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_cause != 3'd0) |-> !hit);

  // R4
  no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_op == 2'd3) |-> !hit);

  // R4
  exec_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && acc_op == OP_EXEC) |-> cfg_q[hit_idx].en_exec);

  // R5
  bad_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_priv == 2'd2) |-> !hit);

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_kind) |=> (cfg_q[$past(wr_idx)] == trig_cfg_t'($past(wr_data[CFG_W-1:0]))));

  // R2
  cmp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind) |=> (cmp_q[$past(wr_idx)] == $past(wr_data)));

  // R10
  end_unchained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !cfg_q[hit_idx].chain);

  // R11
  action_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hit_action == cfg_q[hit_idx].action));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0 && hit_action == 3'd0));

endmodule

bind trig_match_unit trig_match_chk #(.NUM_TRIG(NUM_TRIG), .XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_kind   (wr_kind),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .acc_op    (acc_op),
  .acc_priv  (acc_priv),
  .dbg_cause (dbg_cause),
  .hit       (hit),
  .hit_idx   (hit_idx),
  .hit_action(hit_action),
  .cfg_q     (cfg_q),
  .cmp_q     (cmp_q)
);

// File: tb/tb_trig_match_unit.sv
module tb_trig_match_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int XL = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_kind = 1'b0;
  logic [1:0]    wr_idx = '0;
  logic [XL-1:0] wr_data = '0;
  logic [1:0]    acc_op = 2'd3;
  logic [1:0]    acc_priv = 2'd3;
  logic          acc_narrow = 1'b0;
  logic [XL-1:0] acc_addr = '0;
  logic [XL-1:0] acc_data = '0;
  logic [2:0]    dbg_cause = '0;
  logic          hit;
  logic [1:0]    hit_idx;
  logic [2:0]    hit_action;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic [13:0]   m_cfg [NT];
  logic [XL-1:0] m_cmp [NT];

  trig_match_unit #(.NUM_TRIG(NT), .XLEN(XL)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .acc_op(acc_op), .acc_priv(acc_priv), .acc_narrow(acc_narrow),
    .acc_addr(acc_addr), .acc_data(acc_data), .dbg_cause(dbg_cause),
    .hit(hit), .hit_idx(hit_idx), .hit_action(hit_action)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  function automatic bit one_match(int i, logic [1:0] op, logic [1:0] pv,
                                   logic [XL-1:0] ad, logic [XL-1:0] dt, bit nar);
    logic [13:0]   c = m_cfg[i];
    logic [XL-1:0] t = m_cmp[i];
    logic [XL-1:0] v, msk, vh;
    int            h, ones;
    bit            en_op, en_pv;
    en_op = (op == 0) ? c[8] : (op == 1) ? c[9] : (op == 2) ? c[10] : 1'b0;
    en_pv = (pv == 0) ? c[13] : (pv == 1) ? c[12] : (pv == 3) ? c[11] : 1'b0;
    if (!(en_op && en_pv)) return 0;
    v = c[7] ? dt : ad;
    if (nar) v = {32'd0, v[31:0]};
    h = nar ? 16 : XL/2;
    case (c[2:0])
      3'd0: return v == t;
      3'd1: begin
        ones = 0;
        while (ones < XL && t[ones]) ones++;
        msk = (ones >= XL) ? '0 : ~((64'd1 << ones) - 64'd1);
        return (v & msk) == (t & msk);
      end
      3'd2: return v >= t;
      3'd3: return v < t;
      3'd4: begin msk = t >> h; return (v & msk) == (t & msk); end
      3'd5: begin msk = t >> h; vh = v >> h; return (vh & msk) == (t & msk); end
      default: return 0;
    endcase
  endfunction

  task automatic expect_out(logic [1:0] op, logic [1:0] pv, logic [XL-1:0] ad,
                            logic [XL-1:0] dt, bit nar, logic [2:0] cause,
                            output bit eh, output logic [1:0] ei, output logic [2:0] ea);
    int s, e;
    bit all;
    eh = 0; ei = 0; ea = 0;
    if (cause != 0) return;
    s = 0;
    while (s < NT) begin
      e = s;
      while (e < NT && m_cfg[e][6]) e++;
      if (e >= NT) return;
      all = 1;
      for (int j = s; j <= e; j++) all &= one_match(j, op, pv, ad, dt, nar);
      if (all) begin eh = 1; ei = 2'(e); ea = m_cfg[e][5:3]; return; end
      s = e + 1;
    end
  endtask

  // ---------------- drivers ----------------
  task automatic wr(bit kind, int idx, logic [XL-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind; wr_idx = 2'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (kind) m_cmp[idx] = d; else m_cfg[idx] = d[13:0];
  endtask

  task automatic probe(string req, logic [1:0] op, logic [1:0] pv, logic [XL-1:0] ad,
                       logic [XL-1:0] dt, bit nar, logic [2:0] cause);
    bit eh; logic [1:0] ei; logic [2:0] ea;
    @(negedge clk);
    acc_op = op; acc_priv = pv; acc_addr = ad; acc_data = dt;
    acc_narrow = nar; dbg_cause = cause;
    #1;
    expect_out(op, pv, ad, dt, nar, cause, eh, ei, ea);
    n_checks++;
    if (hit !== eh || hit_idx !== ei || hit_action !== ea) begin
      n_fails++;
      $display("FAIL %s: actual hit=%0b idx=%0d act=%0d expected hit=%0b idx=%0d act=%0d (op=%0d priv=%0d addr=%h data=%h nar=%0b)",
               req, hit, hit_idx, hit_action, eh, ei, ea, op, pv, ad, dt, nar);
    end
  endtask

  function automatic logic [XL-1:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  logic [XL-1:0] pool [10];

  initial begin
    for (int i = 0; i < NT; i++) begin m_cfg[i] = '0; m_cmp[i] = '0; end
    pool[0] = 64'h0;
    pool[1] = 64'h1;
    pool[2] = 64'hFF;
    pool[3] = 64'h100;
    pool[4] = 64'hFFFF_FFFF_8000_0010;
    pool[5] = 64'h0000_0000_8000_0010;
    pool[6] = 64'h1234_5678_9ABC_DEF0;
    pool[7] = 64'hFFFF_FFFF_FFFF_FFFF;
    pool[8] = 64'h0000_00FF_0000_107F;
    pool[9] = 64'h0F0F_0000_00F0_1234;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, nothing fires
    for (int op = 0; op < 4; op++)
      for (int pv = 0; pv < 4; pv++)
        probe("R1", 2'(op), 2'(pv), '0, '0, 1'b0, 3'd0);

    // R4 R5: enable grid x op x priv on trigger 0, equal mode
    wr(1'b1, 0, 64'h100);
    for (int en = 0; en < 64; en++) begin
      wr(1'b0, 0, XL'((en << 8) | (3 << 3)));
      for (int op = 0; op < 4; op++)
        for (int pv = 0; pv < 4; pv++)
          probe("R4/R5", 2'(op), 2'(pv), 64'h100, 64'h0, 1'b0, 3'd0);
    end

    // R6 R7 R8 R9: every mode x compare pool x value pool x width x select
    for (int md = 0; md < 8; md++) begin
      for (int sel = 0; sel < 2; sel++) begin
        wr(1'b0, 0, XL'((14'h3F << 8) | (sel << 7) | (5 << 3) | md));
        for (int ci = 0; ci < 10; ci++) begin
          wr(1'b1, 0, pool[ci]);
          for (int vi = 0; vi < 10; vi++)
            for (int nar = 0; nar < 2; nar++) begin
              if (sel == 1)
                probe((md == 1) ? "R8/R6" : (md >= 4) ? "R9/R6" : "R7/R6",
                      2'd2, 2'd1, ~pool[vi], pool[vi], nar[0], 3'd0);
              else
                probe((md == 1) ? "R8/R6" : (md >= 4) ? "R9/R6" : "R7/R6",
                      2'd0, 2'd3, pool[vi], ~pool[vi], nar[0], 3'd0);
            end
        end
      end
    end

    // R10 R11: all chain patterns x all pass/fail patterns
    for (int i = 0; i < NT; i++) wr(1'b1, i, 64'h0);
    for (int cp = 0; cp < 16; cp++)
      for (int mp = 0; mp < 16; mp++) begin
        for (int i = 0; i < NT; i++)
          wr(1'b0, i, XL'((14'h3F << 8) | (((cp >> i) & 1) << 6) | ((i + 1) << 3) |
                          ((((mp >> i) & 1) != 0) ? 2 : 3)));
        probe("R10/R11", 2'd1, 2'd0, 64'h55, 64'h0, 1'b0, 3'd0);
      end

    // R2: write one trigger only, others unaffected
    for (int i = 0; i < NT; i++) begin
      wr(1'b0, i, XL'((14'h3F << 8) | (i << 3)));
      wr(1'b1, i, 64'hA000 + XL'(i));
    end
    for (int i = 0; i < NT; i++)
      probe("R2", 2'd0, 2'd3, 64'hA000 + XL'(i), 64'h0, 1'b0, 3'd0);
    wr(1'b1, 2, 64'hBEEF);
    probe("R2", 2'd0, 2'd3, 64'hBEEF, 64'h0, 1'b0, 3'd0);
    probe("R2", 2'd0, 2'd3, 64'hA002, 64'h0, 1'b0, 3'd0);

    // R3 and random mix (R2 R10 R11)
    for (int k = 0; k < 600; k++) begin
      int t = int'($urandom_range(0, NT-1));
      if ($urandom_range(0, 1) == 1) wr(1'b1, t, r64());
      else wr(1'b0, t, XL'($urandom() | 32'h3F00));
      begin
        logic [XL-1:0] base = m_cmp[$urandom_range(0, NT-1)];
        logic [XL-1:0] av = ($urandom_range(0, 3) == 0) ? r64() : (base ^ XL'($urandom_range(0, 3)));
        probe("R11", 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), av, av, 1'($urandom()), 3'd0);
        probe("R3", 2'($urandom_range(0, 2)), 2'd3, av, av, 1'($urandom()), 3'($urandom_range(1, 7)));
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule